// File: doc/BRIEF.md
# Coin-Accumulating Vending Controller

This block is a Moore state machine that keeps track of credit in a single-slot vending mechanism. An external coin sensor pulses one of two strobe lines for one clock per coin: one for a 5-cent coin and one for a 10-cent coin. The machine adds up the credit until it reaches the 15-cent price. It then drives a release output for exactly one state, and the mechanism hands out one item.

Credit is held as one of four levels: zero, five, ten and "paid" (15 cents or more). Any overpayment is kept and no change is given. The paid state does not simply clear. A coin that arrives while the machine is in the paid state is credited as the first coin of the next purchase. If both strobes are high in the same cycle, the input is contradictory and the machine holds its current level.

Top module: `coin_vend_ctrl`

## Requirements
- R1: The reset input is active-high and synchronous. After a clock edge with reset high, the credit level is zero and release is 0, whatever the coin inputs are.
- R2: With neither strobe high, the levels zero, five and ten keep their value across clock edges.
- R3: From zero, a 5-cent strobe moves to five and a 10-cent strobe moves to ten.
- R4: From five, a 5-cent strobe moves to ten and a 10-cent strobe moves to paid.
- R5: From ten, either strobe moves to paid. The surplus 5 cents is absorbed and no change is given.
- R6: Release depends only on the registered state. It is 1 exactly in the paid state and 0 in the other three.
- R7: From paid, no coin returns to zero, a 5-cent strobe goes to five and a 10-cent strobe goes to ten. A coin that arrives during the release cycle therefore starts the next purchase.
- R8: When both strobes are high in the same cycle, the state does not change.
- R9: The levels are binary-coded zero=00, five=01, ten=10, paid=11, and the state register updates on the rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to zero credit |
| nickel_i | input | 1 | One-cycle strobe for a 5-cent coin |
| dime_i | input | 1 | One-cycle strobe for a 10-cent coin |
| release_o | output | 1 | High for the one state in which 15 cents or more is held |

## Verification
The bench feeds every route to the price: three small coins, small then large, two small then large, two large with overpayment, and large then small. These routes show that five and ten are kept apart and that ten plus either coin pays. Coins that arrive during the release cycle, of both kinds, show that the paid state credits the new coin instead of clearing. Idle gaps between coins test the hold behaviour. Cycles with both strobes high, followed by a single coin, show that a contradictory input leaves the credit unchanged rather than adding to it. A reset in the middle of a purchase shows that partial credit is discarded.

// File: rtl/coin_vend_pkg.sv
package coin_vend_pkg;

    localparam int LEVEL_COUNT = 4;
    localparam int LEVEL_W     = $clog2(LEVEL_COUNT);

    typedef enum logic [LEVEL_W-1:0] {
        CR_ZERO = 2'b00,
        CR_FIVE = 2'b01,
        CR_TEN  = 2'b10,
        CR_PAID = 2'b11
    } credit_t;

    typedef enum logic [1:0] {
        COIN_NONE,
        COIN_SMALL,
        COIN_LARGE,
        COIN_CLASH
    } coin_t;

    typedef struct packed {
        credit_t credit;
    } vend_state_t;

endpackage

// File: rtl/coin_classify.sv
module coin_classify
    import coin_vend_pkg::*;
(
    input  logic  small_i,
    input  logic  large_i,
    output coin_t coin_o
);
    always_comb begin
        unique case ({large_i, small_i})
            2'b01:   coin_o = COIN_SMALL;
            2'b10:   coin_o = COIN_LARGE;
            2'b11:   coin_o = COIN_CLASH;
            default: coin_o = COIN_NONE;
        endcase
    end
endmodule

// File: rtl/credit_step.sv
module credit_step
    import coin_vend_pkg::*;
(
    input  credit_t cur_i,
    input  coin_t   coin_i,
    output credit_t nxt_o
);
    always_comb begin
        nxt_o = cur_i;
        if (coin_i != COIN_CLASH) begin
            unique case (cur_i)
                CR_ZERO: begin
                    if (coin_i == COIN_SMALL)      nxt_o = CR_FIVE;
                    else if (coin_i == COIN_LARGE) nxt_o = CR_TEN;
                end
                CR_FIVE: begin
                    if (coin_i == COIN_SMALL)      nxt_o = CR_TEN;
                    else if (coin_i == COIN_LARGE) nxt_o = CR_PAID;
                end
                CR_TEN: begin
                    if (coin_i != COIN_NONE)       nxt_o = CR_PAID;
                end
                default: begin
                    // a purchase just completed: new coin opens the next one
                    if (coin_i == COIN_SMALL)      nxt_o = CR_FIVE;
                    else if (coin_i == COIN_LARGE) nxt_o = CR_TEN;
                    else                           nxt_o = CR_ZERO;
                end
            endcase
        end
    end
endmodule

// File: rtl/coin_vend_ctrl.sv
module coin_vend_ctrl
    import coin_vend_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic nickel_i,
    input  logic dime_i,
    output logic release_o
);
    coin_t       coin;
    credit_t     credit_nxt;
    vend_state_t state_d;
    vend_state_t state_q;

    coin_classify u_classify (
        .small_i (nickel_i),
        .large_i (dime_i),
        .coin_o  (coin)
    );

    credit_step u_step (
        .cur_i  (state_q.credit),
        .coin_i (coin),
        .nxt_o  (credit_nxt)
    );

    always_comb begin
        state_d = state_q;
        state_d.credit = rst ? CR_ZERO : credit_nxt;
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign release_o = (state_q.credit == CR_PAID);

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!nickel_i && !dime_i && state_q.credit != CR_PAID) |=> $stable(state_q.credit));

    p_zero_small_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q.credit == CR_ZERO && nickel_i && !dime_i) |=> state_q.credit == CR_FIVE);

    p_five_large_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q.credit == CR_FIVE && dime_i && !nickel_i) |=> release_o);

    p_ten_any_r5: assert property (@(posedge clk) disable iff (rst)
        (state_q.credit == CR_TEN && (nickel_i ^ dime_i)) |=> release_o);

    p_single_release_r7: assert property (@(posedge clk) disable iff (rst)
        (release_o && !(nickel_i && dime_i)) |=> !release_o);

    p_clash_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (nickel_i && dime_i) |=> $stable(state_q.credit));

endmodule

// File: tb/coin_vend_ctrl_test.sv
module coin_vend_ctrl_test;

    typedef struct {
        logic  exp;
        string tag;
    } item_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic nickel_i = 1'b0;
    logic dime_i = 1'b0;
    logic release_o;

    int   n_run  = 0;
    int   n_fail = 0;
    int   lvl    = 0;
    bit   done   = 1'b0;
    item_t q[$];

    always #10 clk = ~clk;

    coin_vend_ctrl uut (
        .clk       (clk),
        .rst       (rst),
        .nickel_i  (nickel_i),
        .dime_i    (dime_i),
        .release_o (release_o)
    );

    task automatic step(input logic r, input logic n, input logic d, input string tag);
        item_t it;
        @(negedge clk);
        rst = r; nickel_i = n; dime_i = d;
        if (r)               lvl = 0;
        else if (n && d)     lvl = lvl;
        else if (lvl == 15)  lvl = n ? 5 : (d ? 10 : 0);
        else begin
            lvl = lvl + (n ? 5 : 0) + (d ? 10 : 0);
            if (lvl > 15) lvl = 15;
        end
        it.exp = (lvl == 15);
        it.tag = tag;
        q.push_back(it);
    endtask

    initial begin : monitor
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                n_run++;
                if (release_o !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: release_o=%b expected %b", it.tag, release_o, it.exp);
                end
            end
        end
    end

    initial begin : watchdog
        #2000000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, got hang expected end");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : driver
        step(1, 1, 0, "R1"); step(1, 0, 1, "R1");
        // three nickels
        step(0, 1, 0, "R3"); step(0, 1, 0, "R4"); step(0, 1, 0, "R5"); step(0, 0, 0, "R7");
        // nickel then dime with idle gap
        step(0, 1, 0, "R3"); step(0, 0, 0, "R2"); step(0, 0, 0, "R2");
        step(0, 0, 1, "R4"); step(0, 0, 0, "R6");
        // two nickels, dime (overpay)
        step(0, 1, 0, "R3"); step(0, 1, 0, "R4"); step(0, 0, 0, "R2");
        step(0, 0, 1, "R5"); step(0, 0, 0, "R7");
        // two dimes
        step(0, 0, 1, "R3"); step(0, 0, 0, "R2"); step(0, 0, 1, "R5"); step(0, 0, 0, "R7");
        // dime then nickel, then a nickel during paid starts next purchase
        step(0, 0, 1, "R3"); step(0, 1, 0, "R5");
        step(0, 1, 0, "R7"); step(0, 1, 0, "R4"); step(0, 1, 0, "R5");
        // dime during paid becomes ten, then nickel pays
        step(0, 0, 1, "R7"); step(0, 1, 0, "R5"); step(0, 0, 0, "R7");
        // clash holds in five: then nickel must not pay, second nickel pays
        step(0, 1, 0, "R3"); step(0, 1, 1, "R8"); step(0, 1, 1, "R8");
        step(0, 1, 0, "R8"); step(0, 1, 0, "R5");
        // clash in paid holds release
        step(0, 1, 1, "R8"); step(0, 0, 0, "R7");
        // clash in zero then dime gives ten, not paid
        step(0, 1, 1, "R8"); step(0, 0, 1, "R9"); step(0, 0, 0, "R2"); step(0, 1, 0, "R9");
        // reset mid-purchase discards credit
        step(0, 0, 1, "R3"); step(1, 1, 0, "R1"); step(0, 1, 0, "R1");
        step(0, 0, 0, "R2"); step(0, 1, 0, "R1"); step(0, 1, 0, "R6");
        step(0, 0, 0, "R6"); step(0, 0, 0, "R2");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule